// File: doc/BRIEF.md
# Low-Power Mode and Clock-Enable Controller

This block manages the clocks and the two sleep modes of a small 8-bit microcontroller core. A single raw oscillator clock drives all of its logic. A divide-by-two phase register turns that clock into enable pulses, so the block does not depend on the input duty cycle. The core writes a two-bit mode-request register. A light sleep stops only the processor enable and leaves the peripheral enable running. A deep sleep stops the oscillator and both enables. Any enabled interrupt wakes the light sleep. Only a hardware reset ends the deep sleep.

A hardware reset that arrives during the light sleep does not take effect at once. The processor keeps running for a takeover window of two machine cycles before the internal reset asserts. Throughout that window, writes to internal RAM are suppressed and writes to port pins pass through unchanged. While the internal reset is active, the block can also capture the external-access strap pin. Whether it does so depends on a lock input.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset is released, the block runs. `cpu_ce` and `per_ce` each pulse once every two `clk` cycles, `osc_run` is 1, `core_rst` is 0 and `pcon_rd` reads 00.
- R2: `rst_in` passes through a two-stage synchroniser. Outside the light sleep, `core_rst` asserts within 4 cycles of `rst_in` rising and stays high for as long as `rst_in` stays high.
- R3: A write with `pcon_wdata` bit 0 set (bit 1 clear) enters the light sleep on the next edge. `cpu_ce` stays 0, `per_ce` keeps pulsing every second cycle, `osc_run` stays 1 and `pcon_rd` reads 01.
- R4: In the light sleep, a 1 on any single bit of `irq_pend` returns the block to the run state on the next edge. This clears the light-sleep bit, so `pcon_rd` reads 00 and `cpu_ce` pulses again.
- R5: A write with `pcon_wdata` bit 1 set enters the deep sleep, and it takes priority when bit 0 is also set. In the deep sleep, `osc_run`, `cpu_ce` and `per_ce` are 0 and `pcon_rd` reads 10.
- R6: In the deep sleep, `irq_pend` and further mode writes have no effect. The block stays in the deep sleep.
- R7: A hardware reset ends the deep sleep. It asserts `core_rst`, and after release the block runs as in R1.
- R8: A reset during the light sleep starts a takeover window of 2 machine cycles (12 divided ticks, 23 or 24 `clk` cycles). During the window `ram_wr_block` is 1, `cpu_ce` keeps pulsing and `core_rst` stays 0. `core_rst` asserts after the window ends.
- R9: `ram_we_o` follows `ram_we_i` one cycle later, but is 0 while `ram_wr_block` is 1. `port_we_o` always follows `port_we_i` one cycle later.
- R10: With `lock1` = 1, `ea_latched` holds the value `ea_pin` had during internal reset and ignores later pin changes. With `lock1` = 0, `ea_latched` follows `ea_pin` one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw oscillator clock |
| rst_in | input | 1 | Asynchronous hardware reset, active high |
| irq_pend | input | N_IRQ | Enabled interrupt requests |
| pcon_we | input | 1 | Mode-request register write strobe |
| pcon_wdata | input | 2 | Mode-request write data: bit 0 light sleep, bit 1 deep sleep |
| ram_we_i | input | 1 | Internal RAM write strobe from the core |
| port_we_i | input | 1 | Port pin write strobe from the core |
| lock1 | input | 1 | Lock bit 1 programmed |
| ea_pin | input | 1 | External-access strap pin |
| cpu_ce | output | 1 | Processor clock enable |
| per_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Internal reset to the core and its registers |
| ram_wr_block | output | 1 | RAM write inhibit during the takeover window |
| ram_we_o | output | 1 | Gated RAM write strobe |
| port_we_o | output | 1 | Port write strobe, never gated |
| pcon_rd | output | 2 | Read-back of the mode-request bits |
| ea_latched | output | 1 | Strap value seen by the core |

## Verification
A wrong mode state shows at the ports on the next cycle. It appears as a missing or extra `cpu_ce` or `per_ce` pulse, or as a changed `pcon_rd` or `osc_run`. A takeover counter that is off by one shifts the assertion of `core_rst` by two cycles and changes the length of `ram_wr_block`, and the bench measures both edges. A strap capture taken at the wrong time shows as a wrong `ea_latched` as soon as the pin changes after reset.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    ST_RST  = 3'd0,
    ST_RUN  = 3'd1,
    ST_IDLE = 3'd2,
    ST_TKO  = 3'd3,
    ST_PD   = 3'd4
  } pm_state_e;
endpackage

// File: rtl/pcc_rst_sync.sv
module pcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    sh_q <= {sh_q[STAGES-2:0], rst_in};
  end

  assign rst_s = sh_q[STAGES-1];
endmodule

// File: rtl/pcc_clk_div.sv
module pcc_clk_div (
  input  logic clk,
  input  logic run,
  output logic ph_q,
  output logic ph_d
);
  // toggle flop: one enable phase per two oscillator periods
  assign ph_d = run ? ~ph_q : 1'b0;

  always_ff @(posedge clk) begin
    ph_q <= ph_d;
  end
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
#(
  parameter int N_IRQ     = 4,
  parameter int WIN_TICKS = 12
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             tick,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             pcon_we,
  input  logic [1:0]       pcon_wdata,
  output pm_state_e        state_q,
  output pm_state_e        state_d
);
  localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_RST:  if (!rst_s) state_d = ST_RUN;
      ST_RUN: begin
        if (rst_s)                        state_d = ST_RST;
        else if (pcon_we && pcon_wdata[1]) state_d = ST_PD;
        else if (pcon_we && pcon_wdata[0]) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (rst_s) begin
          state_d = ST_TKO;
          cnt_d   = '0;
        end else if (|irq_pend) begin
          state_d = ST_RUN;
        end
      end
      ST_TKO: begin
        if (tick) begin
          if (cnt_q == LAST) state_d = ST_RST;
          else               cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_PD:   if (rst_s) state_d = ST_RST;
      default: state_d = ST_RST;
    endcase
  end

  always_ff @(posedge clk) begin
    state_q <= state_d;
    cnt_q   <= cnt_d;
  end
endmodule

// File: rtl/pcc_strap.sv
module pcc_strap (
  input  logic clk,
  input  logic lock1,
  input  logic in_reset,
  input  logic ea_pin,
  output logic ea_q
);
  // no reset: with the lock set, the value is undefined until a reset samples it
  always_ff @(posedge clk) begin
    if (!lock1 || in_reset) ea_q <= ea_pin;
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MC_TICKS    = 6,
  parameter int WIN_MC      = 2
) (
  input  logic             clk,
  input  logic             rst_in,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic             pcon_we,
  input  logic [1:0]       pcon_wdata,
  input  logic             ram_we_i,
  input  logic             port_we_i,
  input  logic             lock1,
  input  logic             ea_pin,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             osc_run,
  output logic             core_rst,
  output logic             ram_wr_block,
  output logic             ram_we_o,
  output logic             port_we_o,
  output logic [1:0]       pcon_rd,
  output logic             ea_latched
);
  localparam int WIN_TICKS = MC_TICKS * WIN_MC;

  logic      rst_s;
  logic      ph_q, ph_d;
  pm_state_e st_q, st_d;
  logic      cpu_act_d;

  pcc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_in(rst_in), .rst_s(rst_s)
  );

  pcc_clk_div u_div (
    .clk(clk), .run(osc_run), .ph_q(ph_q), .ph_d(ph_d)
  );

  pcc_mode_fsm #(.N_IRQ(N_IRQ), .WIN_TICKS(WIN_TICKS)) u_fsm (
    .clk(clk), .rst_s(rst_s), .tick(ph_q), .irq_pend(irq_pend),
    .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
    .state_q(st_q), .state_d(st_d)
  );

  pcc_strap u_strap (
    .clk(clk), .lock1(lock1), .in_reset(st_q == ST_RST),
    .ea_pin(ea_pin), .ea_q(ea_latched)
  );

  assign cpu_act_d = (st_d == ST_RUN) || (st_d == ST_TKO);

  always_ff @(posedge clk) begin
    cpu_ce       <= ph_d & cpu_act_d;
    per_ce       <= ph_d & (st_d != ST_PD);
    osc_run      <= (st_d != ST_PD);
    core_rst     <= (st_d == ST_RST);
    ram_wr_block <= (st_d == ST_TKO);
    ram_we_o     <= ram_we_i & (st_d != ST_TKO);
    port_we_o    <= port_we_i;
    pcon_rd      <= {st_d == ST_PD, st_d == ST_IDLE};
  end
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_in,
  input logic       cpu_ce,
  input logic       per_ce,
  input logic       osc_run,
  input logic       core_rst,
  input logic       ram_wr_block,
  input logic       ram_we_o,
  input logic       port_we_i,
  input logic       port_we_o,
  input logic [1:0] pcon_rd
);
  // R5
  pd_clk_off_chk: assert property (@(posedge clk) disable iff (rst_in)
    !osc_run |-> (!cpu_ce && !per_ce && pcon_rd == 2'b10));

  // R6
  pd_hold_chk: assert property (@(posedge clk) disable iff (rst_in)
    (!osc_run && !core_rst) |=> (!osc_run || core_rst));

  // R3
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (rst_in)
    cpu_ce |-> per_ce);

  // R9
  ram_block_chk: assert property (@(posedge clk) disable iff (rst_in)
    ram_wr_block |-> !ram_we_o);

  // R9
  port_pass_chk: assert property (@(posedge clk) disable iff (rst_in)
    port_we_i |=> port_we_o);

  // R8
  rst_no_cpu_chk: assert property (@(posedge clk) disable iff (rst_in)
    core_rst |-> (!cpu_ce && !ram_wr_block));

  // R3
  pcon_onehot_chk: assert property (@(posedge clk) disable iff (rst_in)
    $onehot0(pcon_rd));
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk u_chk (
  .clk(clk), .rst_in(rst_in), .cpu_ce(cpu_ce), .per_ce(per_ce),
  .osc_run(osc_run), .core_rst(core_rst), .ram_wr_block(ram_wr_block),
  .ram_we_o(ram_we_o), .port_we_i(port_we_i), .port_we_o(port_we_o),
  .pcon_rd(pcon_rd)
);

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;
  localparam int N_IRQ = 4;
  localparam int WIN_TICKS = 6 * 2;

  logic             clk = 1'b0;
  logic             rst_in = 1'b1;
  logic [N_IRQ-1:0] irq_pend = '0;
  logic             pcon_we = 1'b0;
  logic [1:0]       pcon_wdata = 2'b00;
  logic             ram_we_i = 1'b0, port_we_i = 1'b0;
  logic             lock1 = 1'b1, ea_pin = 1'b1;
  logic             cpu_ce, per_ce, osc_run, core_rst, ram_wr_block;
  logic             ram_we_o, port_we_o, ea_latched;
  logic [1:0]       pcon_rd;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_clk_ctrl #(.N_IRQ(N_IRQ)) u_pwr_clk_ctrl (
    .clk(clk), .rst_in(rst_in), .irq_pend(irq_pend), .pcon_we(pcon_we),
    .pcon_wdata(pcon_wdata), .ram_we_i(ram_we_i), .port_we_i(port_we_i),
    .lock1(lock1), .ea_pin(ea_pin), .cpu_ce(cpu_ce), .per_ce(per_ce),
    .osc_run(osc_run), .core_rst(core_rst), .ram_wr_block(ram_wr_block),
    .ram_we_o(ram_we_o), .port_we_o(port_we_o), .pcon_rd(pcon_rd),
    .ea_latched(ea_latched)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_ce(input int n, output int nc, output int np);
    nc = 0; np = 0;
    repeat (n) begin
      @(negedge clk);
      nc += int'(cpu_ce);
      np += int'(per_ce);
    end
  endtask

  task automatic wr_pcon(input logic [1:0] d);
    @(negedge clk);
    pcon_we = 1'b1; pcon_wdata = d;
    @(negedge clk);
    pcon_we = 1'b0; pcon_wdata = 2'b00;
  endtask

  task automatic do_reset(input int hold);
    @(negedge clk);
    rst_in = 1'b1;
    repeat (hold) @(negedge clk);
    rst_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_run(input string req);
    int nc, np;
    count_ce(20, nc, np);
    check({req, " cpu_ce pulses"}, nc, 10);
    check({req, " per_ce pulses"}, np, 10);
    check({req, " osc_run"}, int'(osc_run), 1);
    check({req, " core_rst"}, int'(core_rst), 0);
    check({req, " pcon_rd"}, int'(pcon_rd), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nc, np, blk, cpu_in_blk, ram_leak, port_miss, rst_early, k;
    repeat (10) @(negedge clk);
    rst_in = 1'b0;
    repeat (6) @(negedge clk);
    // R1 reset state
    expect_run("R1");
    // R10 locked strap captured as 1 during reset, pin change ignored
    ea_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 locked hold 1", int'(ea_latched), 1);

    // R2 reset in run state
    @(negedge clk);
    rst_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 core_rst asserted", int'(core_rst), 1);
    repeat (20) @(negedge clk);
    check("R2 core_rst held", int'(core_rst), 1);
    rst_in = 1'b0;
    repeat (6) @(negedge clk);
    expect_run("R2 after release");
    // R10 strap captured 0 in that reset, pin now 1 is ignored
    ea_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 locked hold 0", int'(ea_latched), 0);
    lock1 = 1'b0;
    for (int v = 0; v < 4; v++) begin
      ea_pin = v[0];
      repeat (2) @(negedge clk);
      check("R10 unlocked follow", int'(ea_latched), v & 1);
    end
    lock1 = 1'b1;

    // R9 ram write passes outside window
    ram_we_i = 1'b1; port_we_i = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 ram_we_o pass", int'(ram_we_o), 1);
    check("R9 port_we_o pass", int'(port_we_o), 1);
    ram_we_i = 1'b0; port_we_i = 1'b0;

    // R3 write with no bits set keeps running
    wr_pcon(2'b00);
    expect_run("R3 null write");

    // R3 / R4: sweep each interrupt line as wake source
    for (int i = 0; i < N_IRQ; i++) begin
      wr_pcon(2'b01);
      @(negedge clk);
      check("R3 pcon_rd idle", int'(pcon_rd), 1);
      count_ce(20, nc, np);
      check("R3 cpu_ce stopped", nc, 0);
      check("R3 per_ce running", np, 10);
      check("R3 osc_run", int'(osc_run), 1);
      irq_pend = N_IRQ'(1) << i;
      @(negedge clk);
      irq_pend = '0;
      check("R4 pcon_rd cleared", int'(pcon_rd), 0);
      count_ce(20, nc, np);
      check("R4 cpu_ce resumed", nc, 10);
    end

    // R5 / R6 / R7: both deep-sleep encodings
    for (int m = 2; m < 4; m++) begin
      wr_pcon(2'(m));
      @(negedge clk);
      check("R5 osc_run off", int'(osc_run), 0);
      check("R5 pcon_rd deep", int'(pcon_rd), 2);
      count_ce(20, nc, np);
      check("R5 cpu_ce off", nc, 0);
      check("R5 per_ce off", np, 0);
      irq_pend = '1;
      repeat (10) @(negedge clk);
      irq_pend = '0;
      wr_pcon(2'b01);
      repeat (3) @(negedge clk);
      check("R6 osc_run stays off", int'(osc_run), 0);
      check("R6 pcon_rd stays deep", int'(pcon_rd), 2);
      @(negedge clk);
      rst_in = 1'b1;
      repeat (4) @(negedge clk);
      check("R7 core_rst", int'(core_rst), 1);
      check("R7 osc_run restarted", int'(osc_run), 1);
      rst_in = 1'b0;
      repeat (6) @(negedge clk);
      expect_run("R7 after reset");
    end

    // R8 / R9: reset during light sleep
    wr_pcon(2'b01);
    ram_we_i = 1'b1; port_we_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_in = 1'b1;
    blk = 0; cpu_in_blk = 0; ram_leak = 0; port_miss = 0; rst_early = 0; k = 0;
    repeat (60) begin
      @(negedge clk);
      k++;
      if (ram_wr_block) begin
        blk++;
        cpu_in_blk += int'(cpu_ce);
        if (ram_we_o) ram_leak++;
        if (core_rst) rst_early++;
      end
      if (!port_we_o) port_miss++;
    end
    check("R8 window length ok", int'(blk >= 2*WIN_TICKS-1 && blk <= 2*WIN_TICKS), 1);
    check("R8 cpu runs in window", int'(cpu_in_blk >= WIN_TICKS-1), 1);
    check("R8 no core_rst in window", rst_early, 0);
    check("R8 core_rst after window", int'(core_rst), 1);
    check("R8 block ended", int'(ram_wr_block), 0);
    check("R9 ram writes blocked", ram_leak, 0);
    check("R9 port writes kept", port_miss, 0);
    ram_we_i = 1'b0; port_we_i = 1'b0;
    rst_in = 1'b0;
    repeat (6) @(negedge clk);
    expect_run("R8 after takeover");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule